// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers up to eight interrupt request lines and presents one interrupt signal to a processor. Each line is watched for a low-to-high transition. A transition marks that line as pending. The controller then picks the most urgent pending line that software has not masked and raises `int_out`. When the processor answers with a one-cycle `int_ack` pulse, the controller supplies an 8-bit vector number in that same cycle. It also moves the chosen line from pending to in-service.

While a line is in service, requests of equal or lower urgency are held back, but a more urgent request may still nest on top of it. Software releases the most urgent in-service line by writing the end-of-interrupt code to the command offset. Software controls each line through a readable and writable mask register. The vector base and the end-of-interrupt code are fixed by parameters.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, the mask reads back as 0xFF (all lines disabled), no line is pending or in service, and `int_out` is 0.
- R2: A line becomes pending only on a 0-to-1 transition of its `req_in` bit. Holding the bit high does not raise it again once it has been acknowledged.
- R3: The mask sits at offset 1 (`reg_addr`=1) and can be read and written. Mask bit n = 1 disables line n and bit n = 0 enables it. A read at offset 0 returns 0x00.
- R4: Line 0 is the most urgent and line 7 the least. Among eligible lines, the lowest index is chosen.
- R5: `int_out` is a register. It is 1 in the cycle after the edge at which some unmasked pending line is more urgent than every line in service, and 0 otherwise.
- R6: In a cycle with `int_ack`=1 and a line chosen, `vec_out` = 0x08 + n for chosen line n. At that edge the line's pending bit clears and its in-service bit sets.
- R7: A line in service blocks lines of equal and lower urgency, while a more urgent line still raises `int_out`.
- R8: Writing 0x20 to offset 0 clears only the most urgent in-service bit. Any other value written to offset 0 changes nothing.
- R9: An `int_ack` with no eligible line gives `vec_out` = 0x0F and changes no pending or in-service bit.
- R10: Mask changes never discard pending state. A pending line that is masked and later unmasked is still served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Request lines, edge-sensitive, synchronous to clk |
| reg_addr | input | 1 | Register offset: 0 = command, 1 = mask |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the offset on reg_addr |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector number, valid in the acknowledge cycle |

## Verification
The assertions check on every cycle that:
- `int_out` never rises without an unmasked pending line, and never rises while line 0 is in service.
- An acknowledge that finds no eligible line leaves the in-service set unchanged.
- A served acknowledge adds exactly one in-service bit, and an end-of-interrupt command removes exactly one.
- The vector stays inside the eight-entry window.

Only the bench scenarios can show three further behaviours:
- The priority order among every pair of lines.
- Nesting of a more urgent line over a less urgent one, and the order in which end-of-interrupt writes then release them.
- Retention of pending state across every one of the 256 mask values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned REG_W = 8;
  typedef enum logic {
    OFS_CMD  = 1'b0,
    OFS_MASK = 1'b1
  } irqc_ofs_e;
endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_n
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;

  // A new rising edge wins over a clear on the same line.
  assign rise   = req_in & ~req_q;
  assign pend_n = (pend_q & ~clr) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_in;
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/irqc_service_reg.sv
module irqc_service_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_bits,
  input  logic         eoi,
  output logic [N-1:0] isr_q,
  output logic [N-1:0] isr_n
);
  logic [N-1:0] top_bit;

  // Isolate the lowest set index, which is the most urgent line in service.
  assign top_bit = isr_q & (~isr_q + N'(1));
  assign isr_n   = (isr_q & ~(eoi ? top_bit : '0)) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= isr_n;
  end
endmodule

// File: rtl/irqc_prio_gate.sv
module irqc_prio_gate #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] eligible,
  input  logic [N-1:0] isr,
  output logic [N-1:0] allow
);
  // blk[i] is set when line i or any more urgent line is in service.
  logic [N-1:0] blk;

  assign blk[0] = isr[0];
  for (genvar i = 1; i < N; i++) begin : g_blk
    assign blk[i] = blk[i-1] | isr[i];
  end

  assign allow = eligible & ~blk;
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     allow,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    // With nothing allowed, the index defaults to the least urgent line.
    idx   = IDX_W'(N - 1);
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (allow[i]) begin
        idx   = IDX_W'(i);
        grant = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned       N        = 8,
  parameter logic [REG_W-1:0]  VEC_BASE = 8'h08,
  parameter logic [REG_W-1:0]  EOI_CODE = 8'h20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_in,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             int_out,
  input  logic             int_ack,
  output logic [REG_W-1:0] vec_out
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     mask_q, mask_n;
  logic [N-1:0]     pend_q, pend_n;
  logic [N-1:0]     isr_q, isr_n;
  logic [N-1:0]     allow_now, allow_next;
  logic [N-1:0]     grant_now;
  logic [N-1:0]     ack_set;
  logic [IDX_W-1:0] idx_now;
  logic             mask_wr, eoi_wr;
  logic             int_q;

  assign mask_wr = reg_wr && (reg_addr == OFS_MASK);
  assign eoi_wr  = reg_wr && (reg_addr == OFS_CMD) && (reg_wdata == EOI_CODE);
  assign mask_n  = mask_wr ? reg_wdata[N-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_n;
  end

  irqc_prio_gate #(.N(N)) u_gate_now (
    .eligible (pend_q & ~mask_q),
    .isr      (isr_q),
    .allow    (allow_now)
  );

  irqc_prio_enc #(.N(N)) u_enc (
    .allow (allow_now),
    .idx   (idx_now),
    .grant (grant_now)
  );

  assign ack_set = int_ack ? grant_now : '0;

  irqc_edge_latch #(.N(N)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .req_in (req_in),
    .clr    (ack_set),
    .pend_q (pend_q),
    .pend_n (pend_n)
  );

  irqc_service_reg #(.N(N)) u_isr (
    .clk      (clk),
    .rst      (rst),
    .set_bits (ack_set),
    .eoi      (eoi_wr),
    .isr_q    (isr_q),
    .isr_n    (isr_n)
  );

  // int_out is computed from next-state values, so the registered output
  // always matches the current pending, mask and in-service registers.
  irqc_prio_gate #(.N(N)) u_gate_next (
    .eligible (pend_n & ~mask_n),
    .isr      (isr_n),
    .allow    (allow_next)
  );

  always_ff @(posedge clk) begin
    if (rst) int_q <= 1'b0;
    else     int_q <= |allow_next;
  end

  assign int_out   = int_q;
  assign vec_out   = VEC_BASE + REG_W'(idx_now);
  assign reg_rdata = (reg_addr == OFS_MASK) ? REG_W'(mask_q) : '0;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned N        = 8,
  parameter logic [7:0]  VEC_BASE = 8'h08,
  parameter logic [7:0]  EOI_CODE = 8'h20
) (
  input logic         clk,
  input logic         rst,
  input logic         int_out,
  input logic         int_ack,
  input logic [7:0]   vec_out,
  input logic         reg_wr,
  input logic         reg_addr,
  input logic [7:0]   reg_wdata,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] isr_q
);
  logic eoi_cmd;
  assign eoi_cmd = reg_wr && !reg_addr && (reg_wdata == EOI_CODE);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && pend_q == '0 && isr_q == '0 && !int_out));

  p_int_needs_pending_r5: assert property (@(posedge clk) disable iff (rst)
    int_out |-> ((pend_q & ~mask_q) != '0));

  p_top_service_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    int_out |-> !isr_q[0]);

  p_ack_adds_service_r6: assert property (@(posedge clk) disable iff (rst)
    (int_ack && int_out && !eoi_cmd) |=>
      ($countones(isr_q) == $past($countones(isr_q)) + 1));

  p_vec_window_r6: assert property (@(posedge clk) disable iff (rst)
    int_ack |-> (vec_out >= VEC_BASE && vec_out < VEC_BASE + 8'(N)));

  p_eoi_drops_one_r8: assert property (@(posedge clk) disable iff (rst)
    (eoi_cmd && !int_ack && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q))));

  p_idle_ack_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !int_out && !eoi_cmd) |=> $stable(isr_q));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .N(N), .VEC_BASE(VEC_BASE), .EOI_CODE(EOI_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .int_out   (int_out),
  .int_ack   (int_ack),
  .vec_out   (vec_out),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mask_q    (mask_q),
  .pend_q    (pend_q),
  .isr_q     (isr_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_in = '0;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       int_out;
  logic       int_ack = 1'b0;
  logic [7:0] vec_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .req_in(req_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic eoi();
    wr(1'b0, 8'h20);
  endtask

  task automatic raise(input logic [7:0] b);
    @(negedge clk);
    req_in = req_in | b;
    @(negedge clk);
    #1;
  endtask

  task automatic drop(input logic [7:0] b);
    @(negedge clk);
    req_in = req_in & ~b;
    @(negedge clk);
    #1;
  endtask

  task automatic ack_expect(input string tag, input logic [7:0] exp);
    @(negedge clk);
    int_ack = 1'b1;
    #1;
    chk(tag, vec_out, exp);
    @(negedge clk);
    int_ack = 1'b0;
    #1;
  endtask

  function automatic int low_zero(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (!m[i]) low_zero = i;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    reg_addr = 1'b1; #1;
    chk("R1 mask", reg_rdata, 8'hFF);
    reg_addr = 1'b0; #1;
    chk("R3 offset0 read", reg_rdata, 8'h00);

    wr(1'b1, 8'h00);
    // Each line alone
    for (int n = 0; n < 8; n++) begin
      raise(8'(1 << n));
      chk("R5 single int", {7'd0, int_out}, 8'h01);
      ack_expect("R6 single vec", 8'(8 + n));
      chk("R6 int drops", {7'd0, int_out}, 8'h00);
      eoi();
      chk("R2 held level", {7'd0, int_out}, 8'h00);
      drop(8'(1 << n));
    end

    // Every ordered pair of lines
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (a != b) begin
          raise(8'((1 << a) | (1 << b)));
          chk("R5 pair int", {7'd0, int_out}, 8'h01);
          ack_expect("R4 pair first", 8'(8 + ((a < b) ? a : b)));
          chk("R7 lower blocked", {7'd0, int_out}, 8'h00);
          eoi();
          chk("R8 eoi frees", {7'd0, int_out}, 8'h01);
          ack_expect("R4 pair second", 8'(8 + ((a < b) ? b : a)));
          eoi();
          chk("R8 pair done", {7'd0, int_out}, 8'h00);
          drop(8'((1 << a) | (1 << b)));
        end
      end
    end

    // Nesting and command decoding
    raise(8'h20);
    ack_expect("R6 nest outer", 8'h0D);
    raise(8'h04);
    chk("R7 higher nests", {7'd0, int_out}, 8'h01);
    ack_expect("R7 nest inner", 8'h0A);
    raise(8'h08);
    chk("R7 line3 blocked by 2", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h21);
    chk("R8 other code ignored", {7'd0, int_out}, 8'h00);
    eoi();
    chk("R8 clears most urgent", {7'd0, int_out}, 8'h01);
    ack_expect("R8 line3 served", 8'h0B);
    eoi();
    chk("R8 line5 still held", {7'd0, int_out}, 8'h00);
    eoi();
    chk("R8 all released", {7'd0, int_out}, 8'h00);
    drop(8'hFF);

    // Acknowledge with nothing eligible
    ack_expect("R9 idle vec", 8'h0F);
    chk("R9 idle int", {7'd0, int_out}, 8'h00);
    raise(8'h80);
    chk("R9 line7 not in service", {7'd0, int_out}, 8'h01);
    ack_expect("R9 line7 vec", 8'h0F);
    eoi();
    drop(8'h80);

    // Mask behaviour across all values, all lines pending
    wr(1'b1, 8'hFF);
    raise(8'hFF);
    chk("R3 all masked", {7'd0, int_out}, 8'h00);
    for (int m = 0; m < 256; m++) begin
      wr(1'b1, 8'(m));
      reg_addr = 1'b1; #1;
      chk("R3 mask readback", reg_rdata, 8'(m));
      chk("R10 int vs mask", {7'd0, int_out}, (m != 255) ? 8'h01 : 8'h00);
      if (m != 255) begin
        ack_expect("R4 masked pick", 8'(8 + low_zero(8'(m))));
        eoi();
        drop(8'(1 << low_zero(8'(m))));
        raise(8'(1 << low_zero(8'(m))));
      end
    end
    wr(1'b1, 8'hFF);
    finish_run();
  end
endmodule